// File: doc/BRIEF.md
# Host Command/Status Register with Interrupt Controller

This block is a 16-bit control register that a host reaches at a single address. A write is a command word. It loads the four interrupt enables, clears chosen pending interrupt flags, starts or stops the DMA, receive and transmit engines through separate start and stop bits, and selects the direction of the buffer FIFO. A read returns a status word. The status word shows the enables, the pending flags, the three engine run states, the FIFO full and empty conditions and the FIFO direction.

Single-cycle event pulses from the DMA, receive, transmit and window logic set the pending flags. The block drives one interrupt request that stays high while any flag is both pending and enabled. The engines, the MAC and the FIFO storage sit outside the block. The block only holds their control bits.

Top module: `hcsr_irq_ctrl`

## Requirements
- R1: After an asynchronous reset, all enables, pending flags and run states are 0 and the FIFO direction is write. The status word therefore holds only the FIFO full and empty bits, and `irq_o` is 0.
- R2: Every command write loads the interrupt enables from command bits 3:0 (bit 0 DMA, 1 receive, 2 transmit, 3 window). Status bits 3:0 show the enables from the cycle after the write.
- R3: An event pulse on `evt_i[i]` sets pending flag i (status bit 4+i, in the same source order as R2). The flag stays set until it is acknowledged.
- R4: Writing 1 to command bit 4+i clears pending flag i. A 0 in that bit leaves the flag alone. The word 0x00F0 clears all four flags.
- R5: If an event pulse and an acknowledge of the same flag arrive in the same cycle, the flag remains set.
- R6: Command bits 8, 9 and 10 start the DMA, receive and transmit engines. Status bits 8, 9 and 10 show whether each engine is running.
- R7: Command bits 11, 12 and 13 stop the DMA, receive and transmit engines. The word 0x3800 stops all three. When a start bit and its stop bit are written together, the engine stops.
- R8: A command write with both the start bit and the stop bit of an engine at 0 leaves that engine's run state unchanged.
- R9: Command bit 14 sets the FIFO to read mode and bit 15 sets it to write mode. Status bit 15 reads 1 for read mode. If both bits are written, the result is write mode. If neither is written, the direction is unchanged.
- R10: Status bit 13 follows `fifo_full_i` and bit 14 follows `fifo_empty_i` combinationally. Status bits 12:11 read 0.
- R11: `irq_o` is high exactly while some pending flag and its enable are both set. It follows the registers combinationally.
- R12: A disabled source still records its pending flag. The enable masks only the request line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe, one cycle per write |
| cmd_i | input | 16 | Command word |
| status_o | output | 16 | Status word |
| evt_i | input | 4 | Event pulses: bit 0 DMA, 1 receive, 2 transmit, 3 window |
| fifo_full_i | input | 1 | FIFO full condition |
| fifo_empty_i | input | 1 | FIFO empty condition |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The stimulus table sets enables and pending flags to patterns such as a pending flag with its enable off and several pending flags with mixed enables. These patterns show whether the request line is the masked OR of the flags or just an OR of pending flags. Start and stop words that touch a single engine, several engines, or a start together with its stop separate per-engine edge control from whole-field loading, and they also show whether stop takes priority. Acknowledge words that clear some flags while an event fires on one of them show the set-over-clear ordering. Words with both, one or neither direction bit check the direction priority and the hold behaviour. Directed steps then check the reset state, including reset applied mid-operation, and the combinational path from the FIFO condition inputs to the status word.

// File: rtl/hcsr_pkg.sv
package hcsr_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned N_SRC    = 4;   // dma, rx, tx, window
  localparam int unsigned N_ENG    = 3;   // dma, rx, tx
  localparam int unsigned EN_LSB   = 0;
  localparam int unsigned ACK_LSB  = EN_LSB + N_SRC;
  localparam int unsigned ON_LSB   = ACK_LSB + N_SRC;
  localparam int unsigned OFF_LSB  = ON_LSB + N_ENG;
  localparam int unsigned DIR_RD_B = 14;
  localparam int unsigned DIR_WR_B = 15;
  localparam int unsigned ST_FULL  = 13;
  localparam int unsigned ST_EMPTY = 14;
  localparam int unsigned ST_DIR   = 15;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] en_wr_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, pend_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (we_i) en_q[i] <= en_wr_i[i];
        // set has priority over acknowledge
        if (evt_i[i])               pend_q[i] <= 1'b1;
        else if (we_i && ack_i[i])  pend_q[i] <= 1'b0;
      end
    end

    assert_evt_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> pend_o[i]);
    assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && ack_i[i] && !evt_i[i]) |=> !pend_o[i]);
    assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[i] && !(we_i && ack_i[i])) |=> $stable(pend_o[i]));
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(en_q & pend_q);
endmodule

// File: rtl/engine_run_ctrl.sv
module engine_run_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] on_i,
  input  logic [N-1:0] off_i,
  output logic [N-1:0] run_o
);
  logic [N-1:0] run_q;

  for (genvar i = 0; i < N; i++) begin : g_eng
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                run_q[i] <= 1'b0;
      else if (we_i && off_i[i])  run_q[i] <= 1'b0;  // stop wins
      else if (we_i && on_i[i])   run_q[i] <= 1'b1;
    end

    assert_off_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && off_i[i]) |=> !run_o[i]);
    assert_on_starts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && on_i[i] && !off_i[i]) |=> run_o[i]);
    assert_run_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && (on_i[i] || off_i[i])) |=> $stable(run_o[i]));
  end

  assign run_o = run_q;
endmodule

// File: rtl/fifo_dir_reg.sv
module fifo_dir_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic rd_cmd_i,
  input  logic wr_cmd_i,
  output logic dir_rd_o
);
  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               dir_q <= 1'b0;
    else if (we_i && wr_cmd_i) dir_q <= 1'b0;  // write mode wins
    else if (we_i && rd_cmd_i) dir_q <= 1'b1;
  end

  assign dir_rd_o = dir_q;

  assert_dir_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_cmd_i) |=> !dir_rd_o);
  assert_dir_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rd_cmd_i && !wr_cmd_i) |=> dir_rd_o);
  assert_dir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (rd_cmd_i || wr_cmd_i)) |=> $stable(dir_rd_o));
endmodule

// File: rtl/hcsr_irq_ctrl.sv
module hcsr_irq_ctrl
  import hcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_i,
  output logic [WORD_W-1:0] status_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  output logic              irq_o
);
  logic [N_SRC-1:0] en, pend;
  logic [N_ENG-1:0] run;
  logic             dir_rd;

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmd_we_i),
    .en_wr_i (cmd_i[EN_LSB +: N_SRC]),
    .ack_i   (cmd_i[ACK_LSB +: N_SRC]),
    .evt_i   (evt_i),
    .en_o    (en),
    .pend_o  (pend),
    .irq_o   (irq_o)
  );

  engine_run_ctrl #(.N(N_ENG)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cmd_we_i),
    .on_i   (cmd_i[ON_LSB +: N_ENG]),
    .off_i  (cmd_i[OFF_LSB +: N_ENG]),
    .run_o  (run)
  );

  fifo_dir_reg u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cmd_we_i),
    .rd_cmd_i (cmd_i[DIR_RD_B]),
    .wr_cmd_i (cmd_i[DIR_WR_B]),
    .dir_rd_o (dir_rd)
  );

  always_comb begin
    status_o                    = '0;
    status_o[EN_LSB +: N_SRC]   = en;
    status_o[ACK_LSB +: N_SRC]  = pend;
    status_o[ON_LSB +: N_ENG]   = run;
    status_o[ST_FULL]           = fifo_full_i;
    status_o[ST_EMPTY]          = fifo_empty_i;
    status_o[ST_DIR]            = dir_rd;
  end

  assert_en_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> status_o[EN_LSB +: N_SRC] == $past(cmd_i[EN_LSB +: N_SRC]));
  assert_irq_has_pending_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_o[ACK_LSB +: N_SRC]));
  assert_irq_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_o[EN_LSB +: N_SRC]));
  assert_evt_set_over_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[ACK_LSB] && evt_i[0]) |=> status_o[ACK_LSB]);
endmodule

// File: tb/hcsr_irq_ctrl_test.sv
module hcsr_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] cmd = '0;
  logic [3:0]  evt = '0;
  logic        full = 1'b0;
  logic        empty = 1'b1;
  logic [15:0] status;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hcsr_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_i(cmd), .status_o(status),
    .evt_i(evt), .fifo_full_i(full), .fifo_empty_i(empty), .irq_o(irq)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] cmd;
    logic [3:0]  evt;
    logic        full;
    logic        empty;
    logic [15:0] exp_st;
    logic        exp_irq;
    logic [31:0] tag;
  } vec_t;

  // status = dir<<15 | empty<<14 | full<<13 | run<<8 | pend<<4 | en
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h000F, 4'h0, 1'b0, 1'b1, 16'h400F, 1'b0, "R2"},
    '{1'b0, 16'h0000, 4'h2, 1'b0, 1'b1, 16'h402F, 1'b1, "R3"},
    '{1'b1, 16'h002D, 4'h0, 1'b0, 1'b1, 16'h400D, 1'b0, "R4"},
    '{1'b0, 16'h0000, 4'h9, 1'b0, 1'b1, 16'h409D, 1'b1, "R11"},
    '{1'b1, 16'h0094, 4'h1, 1'b0, 1'b1, 16'h4014, 1'b0, "R5"},
    '{1'b1, 16'h0701, 4'h0, 1'b0, 1'b1, 16'h4711, 1'b1, "R6"},
    '{1'b1, 16'h0A01, 4'h0, 1'b0, 1'b1, 16'h4611, 1'b1, "R7"},
    '{1'b1, 16'h2401, 4'h0, 1'b0, 1'b1, 16'h4211, 1'b1, "R7"},
    '{1'b1, 16'h4001, 4'h0, 1'b1, 1'b0, 16'hA211, 1'b1, "R9"},
    '{1'b0, 16'h0000, 4'h0, 1'b0, 1'b0, 16'h8211, 1'b1, "R10"},
    '{1'b1, 16'h0001, 4'h0, 1'b0, 1'b0, 16'h8211, 1'b1, "R8"},
    '{1'b1, 16'hC0F0, 4'h0, 1'b0, 1'b1, 16'h4200, 1'b0, "R9"},
    '{1'b1, 16'h3800, 4'h0, 1'b0, 1'b1, 16'h4000, 1'b0, "R7"},
    '{1'b0, 16'h0000, 4'h4, 1'b0, 1'b1, 16'h4040, 1'b0, "R12"},
    '{1'b1, 16'h8004, 4'h0, 1'b0, 1'b1, 16'h4044, 1'b1, "R11"}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // drive at negedge, let the posedge load, sample 5 ns later
  task automatic step(input vec_t v);
    @(negedge clk);
    we = v.we; cmd = v.cmd; evt = v.evt; full = v.full; empty = v.empty;
    @(posedge clk);
    #2;
    we = 1'b0; cmd = '0; evt = '0;
    #3;
  endtask

  initial begin
    #25;
    // R1: reset state
    chk(status == 16'h4000, "R1 status", status, 16'h4000);
    chk(irq == 1'b0, "R1 irq", {15'd0, irq}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      step(VECS[k]);
      chk(status == VECS[k].exp_st, $sformatf("%s status row %0d", VECS[k].tag, k), status, VECS[k].exp_st);
      chk(irq == VECS[k].exp_irq, $sformatf("%s irq row %0d", VECS[k].tag, k), {15'd0, irq}, {15'd0, VECS[k].exp_irq});
    end
    // R10: FIFO bits follow inputs without a clock edge
    @(negedge clk);
    full = 1'b1; empty = 1'b0;
    #1;
    chk(status == 16'h2044, "R10 full comb", status, 16'h2044);
    full = 1'b0; empty = 1'b0;
    #1;
    chk(status == 16'h0044, "R10 none comb", status, 16'h0044);
    // R11: enable drop removes request while flag stays
    step('{1'b1, 16'h0000, 4'h0, 1'b0, 1'b1, 16'h4040, 1'b0, "R11"});
    chk(status == 16'h4040, "R11 flag kept", status, 16'h4040);
    chk(irq == 1'b0, "R11 masked", {15'd0, irq}, 16'h0);
    // build state, then reset mid-operation (R1)
    step('{1'b1, 16'h4703, 4'h0, 1'b0, 1'b1, 16'hC743, 1'b0, "R1"});
    chk(status == 16'hC743, "R6 pre-reset", status, 16'hC743);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(status == 16'h4000, "R1 async reset", status, 16'h4000);
    chk(irq == 1'b0, "R1 async irq", {15'd0, irq}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step('{1'b0, 16'h0000, 4'h0, 1'b0, 1'b1, 16'h4000, 1'b0, "R1"});
    chk(status == 16'h4000, "R1 after release", status, 16'h4000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule